// File: doc/BRIEF.md
# Key Event Queue with Repeat Filter

This block sits behind an infrared remote-control frame decoder and turns its stream of decoded frames into an ordered queue of key events. Each event carries a 64-bit key code and a flag telling whether it is a key press (down) or a key release (up). A remote that keeps a key pressed resends the same frame many times; the block removes those duplicates so that one press yields one down event. When the decoder reports that the key was let go, the block can add an up event carrying the code of the last queued event.

Duplicate removal has two modes. With repeat filtering on, every accepted frame restarts a hold-off window counted in millisecond ticks, and while that window is open a frame matching the last queued code is discarded. With repeat filtering off there is no window: a frame is discarded only when the last queued event is a down event with the same code. Events leave the block through a valid/ready read port. The queue holds between 1 and 100 events, set at run time. Settings are loaded with a single write strobe and come out of reset with usable defaults. A push that finds the queue full is lost and raises a sticky overflow flag that the consumer clears.

Top module: `key_event_queue`

## Requirements
- R1: After reset the read port shows no event (evt_valid 0), ovf_flag is 0, and the settings are: repeat filtering on, key-up generation on, hold-off 200 ticks, depth 8.
- R2: Accepted frames appear as down events (evt_is_up 0) in arrival order. Each event is visible on the read port one clock after the edge that accepted it and is removed on a clock where evt_valid and evt_ready are both 1.
- R3: With repeat filtering on and the hold-off window open, a frame whose code equals the code of the last queued event is discarded. A frame with a different code is queued and reopens the window.
- R4: Each queued frame in repeat-filter mode loads the window with the hold-off value. The window closes on the hold-off-th ms_tick after that, and until then a matching frame is still discarded.
- R5: With repeat filtering off, a frame is discarded exactly when the last queued event is a down event with the same code. A matching frame that follows an up event is queued.
- R6: A release strobe closes the hold-off window. When key-up generation is on and the last queued event is a down event, the release queues a copy of it with evt_is_up 1. A release whose last queued event is an up event, or that finds no event queued since reset or since the last depth change, queues nothing.
- R7: With key-up generation off, a release queues nothing.
- R8: The queue holds exactly depth events. A push into a full queue is lost and sets ovf_flag, which stays set until ovf_clr is asserted. A push in the same clock as a pop from a full queue is accepted.
- R9: A settings write with cfg_depth in 1..100 sets the depth, empties the queue and forgets the last queued event. A write with any other cfg_depth leaves the depth and the queued events unchanged.
- R10: In a clock where rel_valid is 1, a frame strobe is ignored and the release is handled. In a clock where cfg_wr is 1, both frame and release strobes are ignored.
- R11: A settings write with cfg_hold_ms equal to 0 keeps the previous hold-off value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-clock pulse per millisecond, drives the hold-off count |
| frm_valid | input | 1 | A decoded frame is present this clock |
| frm_code | input | 64 | Code of the decoded frame |
| rel_valid | input | 1 | The decoder saw the key released |
| cfg_wr | input | 1 | Load the settings below |
| cfg_rep_en | input | 1 | Repeat filtering on (1) or off (0) |
| cfg_up_en | input | 1 | Key-up generation on (1) or off (0) |
| cfg_hold_ms | input | 16 | Hold-off length in ticks, 0 ignored |
| cfg_depth | input | 7 | Queue depth, 1..100 accepted |
| ovf_clr | input | 1 | Clear the overflow flag |
| evt_valid | output | 1 | An event is available |
| evt_code | output | 64 | Code of the event at the head of the queue |
| evt_is_up | output | 1 | 1 for an up event, 0 for a down event |
| evt_ready | input | 1 | Consumer takes the event |
| ovf_flag | output | 1 | Sticky: a push was lost to a full queue |

## Verification
Two pairs of functions can meet in one clock. A frame and a release strobe can arrive together, and the bench drives both in the same cycle right after a press and expects the up copy of the earlier code and no trace of the new frame. A pop and a push can also land on a full queue at once, and the bench fills the queue to its default depth, pops the head while pushing a new code in that same clock, then drains the queue expecting the new code last and the earlier lost push absent.

// File: rtl/keyq_pkg.sv
package keyq_pkg;
  localparam int CODE_W = 64;

  typedef struct packed {
    logic              up;
    logic [CODE_W-1:0] code;
  } key_evt_t;
endpackage

// File: rtl/keyq_holdoff.sv
module keyq_holdoff #(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic              stop,
  input  logic [HOLD_W-1:0] hold,
  output logic              active
);
  logic [HOLD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= hold;
    end else if (stop) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active && tick) begin
      if (cnt <= HOLD_W'(1)) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt - HOLD_W'(1);
      end
    end
  end

  AST_HOLD_OPENS: assert property (@(posedge clk) disable iff (rst) start |=> active); // R4
  AST_HOLD_NO_EARLY: assert property (@(posedge clk) disable iff (rst) (active && !tick && !stop) |=> active); // R4
  AST_STOP_CLOSES: assert property (@(posedge clk) disable iff (rst) (stop && !start) |=> !active); // R6
endmodule

// File: rtl/keyq_ring.sv
module keyq_ring
  import keyq_pkg::*;
#(
  parameter int SLOTS = 101,
  parameter int PTR_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PTR_W-1:0] last_idx,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  key_evt_t         wdata,
  output logic             full,
  output logic [PTR_W-1:0] head_o,
  output logic             rd_valid,
  output key_evt_t         rd_data
);
  key_evt_t         mem [SLOTS];
  logic [PTR_W-1:0] head, tail;
  logic [PTR_W-1:0] head_inc, tail_inc, head_n, tail_n;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p,
                                            input logic [PTR_W-1:0] lim);
    return (p >= lim) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    head_inc = step(head, last_idx);
    tail_inc = step(tail, last_idx);
    full     = (head_inc == tail);
    head_n   = clr ? '0 : (push ? head_inc : head);
    tail_n   = clr ? '0 : (pop ? tail_inc : tail);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head     <= '0;
      tail     <= '0;
      rd_valid <= 1'b0;
    end else begin
      head     <= head_n;
      tail     <= tail_n;
      rd_valid <= (head_n != tail_n);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[head] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (push && (head == tail_n)) rd_data <= wdata;
    else                          rd_data <= mem[tail_n];
  end

  assign head_o = head;

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst) (head <= last_idx) && (tail <= last_idx)); // R8
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst) (rd_valid && !pop && !clr) |=> rd_valid); // R2
endmodule

// File: rtl/key_event_queue.sv
module key_event_queue
  import keyq_pkg::*;
#(
  parameter int MAX_DEPTH = 100,
  parameter int DEF_DEPTH = 8,
  parameter int HOLD_W    = 16,
  parameter int DEF_HOLD  = 200,
  localparam int SLOTS    = MAX_DEPTH + 1,
  localparam int PTR_W    = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_tick,
  input  logic              frm_valid,
  input  logic [CODE_W-1:0] frm_code,
  input  logic              rel_valid,
  input  logic              cfg_wr,
  input  logic              cfg_rep_en,
  input  logic              cfg_up_en,
  input  logic [HOLD_W-1:0] cfg_hold_ms,
  input  logic [PTR_W-1:0]  cfg_depth,
  input  logic              ovf_clr,
  output logic              evt_valid,
  output logic [CODE_W-1:0] evt_code,
  output logic              evt_is_up,
  input  logic              evt_ready,
  output logic              ovf_flag
);
  logic [PTR_W-1:0]  depth_q;
  logic              rep_q, up_q;
  logic [HOLD_W-1:0] hold_q;
  logic              last_vld;
  key_evt_t          last_evt;

  logic     depth_ok, clr;
  logic     frm_go, rel_go, same, frm_drop, frm_push, rel_push;
  logic     push_req, push_ok, pop, full, hold_active;
  key_evt_t wdata, rd_data;
  logic [PTR_W-1:0] head;

  always_comb begin
    depth_ok = (cfg_depth != '0) && (cfg_depth <= PTR_W'(MAX_DEPTH));
    clr      = cfg_wr && depth_ok;
    frm_go   = frm_valid && !rel_valid && !cfg_wr;
    rel_go   = rel_valid && !cfg_wr;
    same     = last_vld && (last_evt.code == frm_code);
    frm_drop = rep_q ? (hold_active && same) : (same && !last_evt.up);
    frm_push = frm_go && !frm_drop;
    rel_push = rel_go && up_q && last_vld && !last_evt.up;
    push_req = frm_push || rel_push;
    wdata.up   = !frm_push;
    wdata.code = frm_push ? frm_code : last_evt.code;
    pop      = evt_valid && evt_ready;
    push_ok  = push_req && (!full || pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_q <= PTR_W'(DEF_DEPTH);
      rep_q   <= 1'b1;
      up_q    <= 1'b1;
      hold_q  <= HOLD_W'(DEF_HOLD);
    end else if (cfg_wr) begin
      rep_q <= cfg_rep_en;
      up_q  <= cfg_up_en;
      if (cfg_hold_ms != '0) hold_q  <= cfg_hold_ms;
      if (depth_ok)          depth_q <= cfg_depth;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      last_vld <= 1'b0;
      last_evt <= '0;
    end else if (push_ok) begin
      last_vld <= 1'b1;
      last_evt <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                       ovf_flag <= 1'b0;
    else if (push_req && !push_ok) ovf_flag <= 1'b1;
    else if (ovf_clr)              ovf_flag <= 1'b0;
  end

  keyq_holdoff #(.HOLD_W(HOLD_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .tick   (ms_tick),
    .start  (frm_push && rep_q),
    .stop   (rel_go),
    .hold   (hold_q),
    .active (hold_active)
  );

  keyq_ring #(.SLOTS(SLOTS), .PTR_W(PTR_W)) u_ring (
    .clk      (clk),
    .rst      (rst),
    .last_idx (depth_q),
    .clr      (clr),
    .push     (push_ok),
    .pop      (pop),
    .wdata    (wdata),
    .full     (full),
    .head_o   (head),
    .rd_valid (evt_valid),
    .rd_data  (rd_data)
  );

  assign evt_code  = rd_data.code;
  assign evt_is_up = rd_data.up;

  AST_DUP_DROPPED: assert property (@(posedge clk) disable iff (rst) (frm_valid && !rel_valid && !cfg_wr && rep_q && hold_active && last_vld && (last_evt.code == frm_code)) |=> $stable(head)); // R3
  AST_NOREP_DROP: assert property (@(posedge clk) disable iff (rst) (frm_valid && !rel_valid && !cfg_wr && !rep_q && last_vld && !last_evt.up && (last_evt.code == frm_code)) |=> $stable(head)); // R5
  AST_NO_UP_WHEN_OFF: assert property (@(posedge clk) disable iff (rst) (rel_valid && !cfg_wr && !up_q) |=> $stable(head)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) (ovf_flag && !ovf_clr) |=> ovf_flag); // R8
  AST_DEPTH_CLEARS: assert property (@(posedge clk) disable iff (rst) (cfg_wr && depth_ok) |=> (!evt_valid && (head == '0))); // R9
  AST_RELEASE_WINS: assert property (@(posedge clk) disable iff (rst) (frm_valid && rel_valid && !cfg_wr && (!up_q || !last_vld || last_evt.up)) |=> $stable(head)); // R10
endmodule

// File: tb/key_event_queue_tb.sv
`timescale 1ns/1ps
module key_event_queue_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ms_tick = 1'b0;
  logic        frm_valid = 1'b0;
  logic [63:0] frm_code = '0;
  logic        rel_valid = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_rep_en = 1'b0;
  logic        cfg_up_en = 1'b0;
  logic [15:0] cfg_hold_ms = '0;
  logic [6:0]  cfg_depth = '0;
  logic        ovf_clr = 1'b0;
  logic        evt_ready = 1'b0;
  logic        evt_valid, evt_is_up, ovf_flag;
  logic [63:0] evt_code;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  key_event_queue u_dut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick),
    .frm_valid(frm_valid), .frm_code(frm_code), .rel_valid(rel_valid),
    .cfg_wr(cfg_wr), .cfg_rep_en(cfg_rep_en), .cfg_up_en(cfg_up_en),
    .cfg_hold_ms(cfg_hold_ms), .cfg_depth(cfg_depth), .ovf_clr(ovf_clr),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_is_up(evt_is_up),
    .evt_ready(evt_ready), .ovf_flag(ovf_flag)
  );

  function automatic logic [63:0] kc(input int i);
    return 64'hA5A5_0000_0000_0000 | 64'(i);
  endfunction

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [63:0] c);
    @(negedge clk); frm_valid = 1'b1; frm_code = c;
    @(negedge clk); frm_valid = 1'b0;
  endtask

  task automatic release_key();
    @(negedge clk); rel_valid = 1'b1;
    @(negedge clk); rel_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ms_tick = 1'b1;
      @(negedge clk); ms_tick = 1'b0;
    end
  endtask

  task automatic setup(input logic rep, input logic up, input logic [15:0] hold, input logic [6:0] depth);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_rep_en = rep; cfg_up_en = up; cfg_hold_ms = hold; cfg_depth = depth;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic pop_exp(input string tag, input logic [63:0] c, input logic up);
    chk(tag, {6'd0, evt_valid, evt_is_up, evt_code}, {6'd0, 1'b1, up, c});
    evt_ready = 1'b1;
    @(negedge clk); evt_ready = 1'b0;
  endtask

  task automatic empty_exp(input string tag);
    chk(tag, {71'd0, evt_valid}, 72'd0);
  endtask

  task automatic t_reset();
    chk("R1 reset valid", {71'd0, evt_valid}, 72'd0);
    chk("R1 reset ovf", {71'd0, ovf_flag}, 72'd0);
  endtask

  task automatic t_hold_default();
    frame(kc(1));
    frame(kc(1));
    pop_exp("R2 first frame down", kc(1), 1'b0);
    empty_exp("R3 repeat dropped in window");
    ticks(199);
    frame(kc(1));
    empty_exp("R1 default hold 200 still open after 199");
    ticks(1);
    frame(kc(1));
    pop_exp("R4 window closed after hold ticks", kc(1), 1'b0);
    frame(kc(2));
    frame(kc(1));
    pop_exp("R3 other code accepted", kc(2), 1'b0);
    pop_exp("R3 code after other accepted", kc(1), 1'b0);
    empty_exp("R2 drained");
  endtask

  task automatic t_overflow();
    for (int i = 10; i < 18; i++) frame(kc(i));
    chk("R8 no ovf at depth", {71'd0, ovf_flag}, 72'd0);
    frame(kc(99));
    chk("R1 default depth 8 ovf", {71'd0, ovf_flag}, 72'd1);
    repeat (3) @(negedge clk);
    chk("R8 ovf sticky", {71'd0, ovf_flag}, 72'd1);
    chk("R8 head before pop", {6'd0, evt_valid, evt_is_up, evt_code}, {6'd0, 1'b1, 1'b0, kc(10)});
    evt_ready = 1'b1; frm_valid = 1'b1; frm_code = kc(50);
    @(negedge clk); evt_ready = 1'b0; frm_valid = 1'b0;
    for (int i = 11; i < 18; i++) pop_exp("R2 order after full", kc(i), 1'b0);
    pop_exp("R8 push with pop on full", kc(50), 1'b0);
    empty_exp("R8 lost push absent");
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    chk("R8 ovf cleared", {71'd0, ovf_flag}, 72'd0);
  endtask

  task automatic t_release();
    frame(kc(20));
    release_key();
    release_key();
    frame(kc(20));
    pop_exp("R6 press", kc(20), 1'b0);
    pop_exp("R6 up copy", kc(20), 1'b1);
    pop_exp("R6 release closed window", kc(20), 1'b0);
    empty_exp("R6 second release no event");
  endtask

  task automatic t_keyup_off();
    setup(1'b1, 1'b0, 16'd5, 7'd8);
    frame(kc(30));
    release_key();
    pop_exp("R7 press", kc(30), 1'b0);
    empty_exp("R7 no up event");
  endtask

  task automatic t_norep();
    setup(1'b0, 1'b1, 16'd5, 7'd8);
    frame(kc(40));
    frame(kc(40));
    frame(kc(41));
    frame(kc(40));
    release_key();
    frame(kc(40));
    pop_exp("R5 first", kc(40), 1'b0);
    pop_exp("R5 other", kc(41), 1'b0);
    pop_exp("R5 back to first", kc(40), 1'b0);
    pop_exp("R5 up", kc(40), 1'b1);
    pop_exp("R5 after up accepted", kc(40), 1'b0);
    empty_exp("R5 duplicate dropped");
  endtask

  task automatic t_depth();
    setup(1'b0, 1'b1, 16'd5, 7'd3);
    for (int i = 60; i < 64; i++) frame(kc(i));
    chk("R8 depth 3 ovf", {71'd0, ovf_flag}, 72'd1);
    setup(1'b0, 1'b1, 16'd5, 7'd0);
    chk("R9 depth 0 ignored", {6'd0, evt_valid, evt_is_up, evt_code}, {6'd0, 1'b1, 1'b0, kc(60)});
    setup(1'b0, 1'b1, 16'd5, 7'd101);
    chk("R9 depth 101 ignored", {6'd0, evt_valid, evt_is_up, evt_code}, {6'd0, 1'b1, 1'b0, kc(60)});
    setup(1'b0, 1'b1, 16'd5, 7'd1);
    empty_exp("R9 valid depth empties");
    frame(kc(62));
    frame(kc(64));
    pop_exp("R9 last forgotten depth 1", kc(62), 1'b0);
    empty_exp("R9 depth 1 holds one");
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    setup(1'b0, 1'b1, 16'd5, 7'd100);
    for (int i = 0; i < 101; i++) frame(kc(200 + i));
    chk("R8 depth 100 ovf", {71'd0, ovf_flag}, 72'd1);
    for (int i = 0; i < 100; i++) pop_exp("R9 depth 100 order", kc(200 + i), 1'b0);
    empty_exp("R9 depth 100 drained");
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
  endtask

  task automatic t_coincide();
    setup(1'b1, 1'b1, 16'd50, 7'd8);
    frame(kc(70));
    @(negedge clk); frm_valid = 1'b1; frm_code = kc(71); rel_valid = 1'b1;
    @(negedge clk); frm_valid = 1'b0; rel_valid = 1'b0;
    pop_exp("R10 press", kc(70), 1'b0);
    pop_exp("R10 release handled", kc(70), 1'b1);
    empty_exp("R10 frame with release ignored");
    @(negedge clk);
    frm_valid = 1'b1; frm_code = kc(72);
    cfg_wr = 1'b1; cfg_rep_en = 1'b1; cfg_up_en = 1'b1; cfg_hold_ms = 16'd50; cfg_depth = 7'd0;
    @(negedge clk); frm_valid = 1'b0; cfg_wr = 1'b0;
    empty_exp("R10 frame with cfg write ignored");
  endtask

  task automatic t_hold_zero();
    setup(1'b1, 1'b1, 16'd3, 7'd8);
    setup(1'b1, 1'b1, 16'd0, 7'd8);
    frame(kc(80));
    frame(kc(80));
    ticks(2);
    frame(kc(80));
    pop_exp("R11 press", kc(80), 1'b0);
    empty_exp("R11 window kept at 3");
    ticks(1);
    frame(kc(80));
    pop_exp("R11 closes at 3 ticks", kc(80), 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_hold_default();
    t_overflow();
    t_release();
    t_keyup_off();
    t_norep();
    t_depth();
    t_coincide();
    t_hold_zero();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule